// File: doc/BRIEF.md
# Oscillator Coarse-Band Calibration Engine

This block runs the coarse-tuning search that comes before a synthesizer loop closes. The chip has three oscillators, and each one has 128 capacitor bands whose ranges overlap. Adding capacitance lowers the frequency. When the enable rises, or when a relock pulse arrives while the block is enabled, the engine sets band 0 on the first oscillator. It then measures that oscillator with a counter, and the counter's window is a fixed number of phase-detector clock cycles. It compares the measured count with a target taken from the divider word of the active bank. It then steps the band upward one code at a time and keeps the first band whose count is at or below the target. If band 127 of an oscillator still counts above the target, the search moves to the next oscillator.

When the search ends, the engine raises a done flag and a loop-enable output. The chosen oscillator, the band code and a failure flag are held steady for readback. The two end codes of the band range are reserved to report failure: a final band of 0 or 127 sets the failure flag. The engine runs on the phase-detector clock, so a faster comparison clock shortens the calibration.

The measured oscillator reaches the block as a single-bit pulse line, `osc_edge`, which carries one pulse per prescaled oscillator period. The block drives `meas_gate` so that the frequency model outside it knows when the counting window is open.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is held, `meas_gate`, `cal_osc`, `cal_band`, `cal_done`, `cal_fail` and `lock_en` are all 0.
- R2: A rising `enable` starts a calibration at oscillator 0, band 0, and clears `cal_done`, `cal_fail` and `lock_en`.
- R3: A one-cycle `relock` while `enable` is high restarts the search from oscillator 0, band 0, even in the middle of a calibration. A `relock` while `enable` is low has no effect on any output.
- R4: Each measurement holds `meas_gate` high for exactly 2^WIN_LOG2 cycles and counts the `osc_edge` pulses seen during that window. Before every window, `meas_gate` stays low for at least one cycle: the cycle after a trigger, and the cycle after each window.
- R5: The target count is (div << WIN_LOG2) >> PRE_LOG2. Here div is `div_a` when `bank_sel`=0 and `div_b` when `bank_sel`=1. The target is captured at the trigger, so later changes to `bank_sel`, `div_a` or `div_b` do not affect that calibration.
- R6: The band code steps up by one per measurement, and the search accepts the first band whose count is less than or equal to the target.
- R7: If band 127 is rejected, the search moves to the next oscillator at band 0. If band 127 of oscillator 2 is rejected, calibration ends with oscillator 2, band 127 and `cal_fail`=1.
- R8: `cal_fail` is 1 exactly when the final band code is 0 or 127. Final codes 1 to 126 leave it at 0.
- R9: With n measurements in total, `cal_done` rises n·(2^WIN_LOG2+1)+2 clock edges after the edge that registers the trigger, where that edge counts as the first.
- R10: `lock_en` rises together with `cal_done`. A low `enable` stops any calibration, and from the next edge on it holds `lock_en` and `meas_gate` low.
- R11: After completion, `cal_osc`, `cal_band`, `cal_done` and `cal_fail` stay unchanged until the next trigger, including while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; its rising edge triggers calibration |
| relock | input | 1 | Self-clearing restart pulse |
| bank_sel | input | 1 | Active divider bank (0 = A, 1 = B) |
| div_a | input | DIV_W | Divider word of bank A |
| div_b | input | DIV_W | Divider word of bank B |
| osc_edge | input | 1 | Prescaled oscillator pulse, one per period |
| meas_gate | output | 1 | Counting window open |
| cal_osc | output | OSC_W | Oscillator under test or chosen |
| cal_band | output | BAND_W | Band code under test or chosen |
| cal_done | output | 1 | Calibration finished |
| cal_fail | output | 1 | Final band is an end code |
| lock_en | output | 1 | Permission for the loop to close |

## Verification
The key result is the completion edge. It comes one arming cycle after the trigger, plus 2^WIN_LOG2+1 cycles for every measurement, plus the decision edge. The bench works out the number of measurements from its own oscillator model. It then checks at the falling edge just before the expected edge that `cal_done` is still low, and at the falling edge just after it that it is high. The gate is checked low in the arming cycle and high in the cycle after. Every probe lands on a falling edge, half a period away from the edge that updates the registers.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2,
    ST_DONE = 2'd3
  } cal_state_t;

endpackage

// File: rtl/vbc_trigger.sv
module vbc_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic relock,
  output logic start,
  output logic halt
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  // a rising enable or a relock while enabled both restart the search
  assign start = enable & (~en_q | relock);
  assign halt  = ~enable;
endmodule

// File: rtl/vbc_freq_meter.sv
module vbc_freq_meter #(
  parameter int WIN_LOG2 = 6,
  parameter int CNT_W    = WIN_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic             osc_edge,
  output logic             gate,
  output logic             cnt_valid,
  output logic [CNT_W-1:0] cnt_value
);
  logic                active;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [CNT_W-1:0]    acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      win_cnt   <= '0;
      acc       <= '0;
      cnt_valid <= 1'b0;
    end else if (abort) begin
      active    <= 1'b0;
      win_cnt   <= '0;
      cnt_valid <= 1'b0;
    end else begin
      cnt_valid <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        win_cnt <= '0;
        acc     <= '0;
      end else if (active) begin
        acc     <= acc + CNT_W'(osc_edge);
        win_cnt <= win_cnt + 1'b1;
        if (&win_cnt) begin
          active    <= 1'b0;
          cnt_valid <= 1'b1;
        end
      end
    end
  end

  assign gate      = active;
  assign cnt_value = acc;
endmodule

// File: rtl/vbc_search.sv
module vbc_search
  import vbc_pkg::*;
#(
  parameter int N_OSC  = 3,
  parameter int OSC_W  = 2,
  parameter int BAND_W = 7,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic [CMP_W-1:0]  tgt_in,
  input  logic              cnt_valid,
  input  logic [CMP_W-1:0]  cnt_value,
  output logic              meas_start,
  output logic              meas_abort,
  output logic [OSC_W-1:0]  osc_sel,
  output logic [BAND_W-1:0] band,
  output logic              done,
  output logic              fail,
  output logic              lock_en
);
  cal_state_t       state;
  logic [CMP_W-1:0] tgt_q;
  logic             accept;
  logic             last_band;
  logic             last_osc;
  logic             band_edge;

  assign accept    = (cnt_value <= tgt_q);
  assign last_band = &band;
  assign band_edge = (band == '0) || last_band;

  generate
    if (N_OSC > 1) begin : g_multi
      assign last_osc = (osc_sel == OSC_W'(N_OSC - 1));
    end else begin : g_single
      assign last_osc = 1'b1;
    end
  endgenerate

  assign meas_abort = start | halt;
  assign meas_start = (state == ST_ARM) ||
                      ((state == ST_MEAS) && cnt_valid && !accept && !(last_band && last_osc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tgt_q   <= '0;
      osc_sel <= '0;
      band    <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      lock_en <= 1'b0;
    end else if (halt) begin
      state   <= ST_IDLE;
      lock_en <= 1'b0;
    end else if (start) begin
      state   <= ST_ARM;
      tgt_q   <= tgt_in;
      osc_sel <= '0;
      band    <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      lock_en <= 1'b0;
    end else begin
      case (state)
        ST_ARM: state <= ST_MEAS;
        ST_MEAS: begin
          if (cnt_valid) begin
            if (accept) begin
              state   <= ST_DONE;
              done    <= 1'b1;
              lock_en <= 1'b1;
              fail    <= band_edge;
            end else if (!last_band) begin
              band <= band + 1'b1;
            end else if (!last_osc) begin
              osc_sel <= osc_sel + 1'b1;
              band    <= '0;
            end else begin
              state   <= ST_DONE;
              done    <= 1'b1;
              lock_en <= 1'b1;
              fail    <= 1'b1;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
  parameter int N_OSC    = 3,
  parameter int BAND_W   = 7,
  parameter int DIV_W    = 10,
  parameter int WIN_LOG2 = 6,
  parameter int PRE_LOG2 = 8,
  localparam int OSC_W   = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              relock,
  input  logic              bank_sel,
  input  logic [DIV_W-1:0]  div_a,
  input  logic [DIV_W-1:0]  div_b,
  input  logic              osc_edge,
  output logic              meas_gate,
  output logic [OSC_W-1:0]  cal_osc,
  output logic [BAND_W-1:0] cal_band,
  output logic              cal_done,
  output logic              cal_fail,
  output logic              lock_en
);
  localparam int CNT_W  = WIN_LOG2 + 1;
  localparam int PROD_W = DIV_W + WIN_LOG2;
  localparam int CMP_W  = (PROD_W > CNT_W) ? PROD_W : CNT_W;

  logic              start;
  logic              halt;
  logic              meas_start;
  logic              meas_abort;
  logic              cnt_valid;
  logic [CNT_W-1:0]  cnt_raw;
  logic [DIV_W-1:0]  div_sel;
  logic [PROD_W-1:0] tgt_full;

  assign div_sel  = bank_sel ? div_b : div_a;
  assign tgt_full = {div_sel, {WIN_LOG2{1'b0}}} >> PRE_LOG2;

  vbc_trigger u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .relock (relock),
    .start  (start),
    .halt   (halt)
  );

  vbc_freq_meter #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (meas_abort),
    .start     (meas_start),
    .osc_edge  (osc_edge),
    .gate      (meas_gate),
    .cnt_valid (cnt_valid),
    .cnt_value (cnt_raw)
  );

  vbc_search #(.N_OSC(N_OSC), .OSC_W(OSC_W), .BAND_W(BAND_W), .CMP_W(CMP_W)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .halt       (halt),
    .tgt_in     (CMP_W'(tgt_full)),
    .cnt_valid  (cnt_valid),
    .cnt_value  (CMP_W'(cnt_raw)),
    .meas_start (meas_start),
    .meas_abort (meas_abort),
    .osc_sel    (cal_osc),
    .band       (cal_band),
    .done       (cal_done),
    .fail       (cal_fail),
    .lock_en    (lock_en)
  );
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int OSC_W  = 2,
  parameter int BAND_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              relock,
  input logic              meas_gate,
  input logic [OSC_W-1:0]  cal_osc,
  input logic [BAND_W-1:0] cal_band,
  input logic              cal_done,
  input logic              cal_fail,
  input logic              lock_en
);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && relock) |=> (!cal_done && !meas_gate && cal_band == '0 && cal_osc == '0));

  p_gate_excl_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_gate |-> !cal_done);

  p_band_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_band) |-> (cal_band == BAND_W'($past(cal_band) + 1'b1)) || (cal_band == '0));

  p_fail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fail |-> cal_done);

  p_success_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_fail) |-> (cal_band != '0 && cal_band != '1));

  p_lock_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_en |-> cal_done);

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!lock_en && !meas_gate));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && enable && $past(enable) && !relock) |=>
      ($stable(cal_band) && $stable(cal_osc) && $stable(cal_fail) && cal_done));
endmodule

bind vco_band_cal vbc_checker #(.OSC_W(OSC_W), .BAND_W(BAND_W)) u_vbc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .relock    (relock),
  .meas_gate (meas_gate),
  .cal_osc   (cal_osc),
  .cal_band  (cal_band),
  .cal_done  (cal_done),
  .cal_fail  (cal_fail),
  .lock_en   (lock_en)
);

// File: tb/test_vco_band_cal.sv
module test_vco_band_cal;
  localparam int WIN  = 64;
  localparam int STEP = 150;
  // kind (0 = enable rise, 1 = relock), div_a, div_b, bank_sel
  localparam int TV [6][4] = '{
    '{0, 200,  13, 0},
    '{1, 140, 999, 0},
    '{0, 240,   0, 0},
    '{1,  20,   0, 0},
    '{0, 200,  80, 1},
    '{1, 156,   0, 0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       relock = 1'b0;
  logic       bank_sel = 1'b0;
  logic [9:0] div_a = '0;
  logic [9:0] div_b = '0;
  logic       osc_edge;
  logic       meas_gate;
  logic [1:0] cal_osc;
  logic [6:0] cal_band;
  logic       cal_done, cal_fail, lock_en;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vco_band_cal i_vco_band_cal (
    .clk(clk), .rst_n(rst_n), .enable(enable), .relock(relock),
    .bank_sel(bank_sel), .div_a(div_a), .div_b(div_b), .osc_edge(osc_edge),
    .meas_gate(meas_gate), .cal_osc(cal_osc), .cal_band(cal_band),
    .cal_done(cal_done), .cal_fail(cal_fail), .lock_en(lock_en)
  );

  function automatic int base_rate(input int v);
    return (v == 0) ? 60000 : (v == 1) ? 45000 : 30000;
  endfunction

  // behavioural oscillator: phase accumulator, carry is one prescaled period
  logic [15:0] phase;
  logic [15:0] rate;
  logic [16:0] sum;
  always_comb begin
    rate = 16'(base_rate(int'(cal_osc)) - int'(cal_band) * STEP);
    sum  = {1'b0, phase} + {1'b0, rate};
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      osc_edge <= 1'b0;
    end else if (!meas_gate) begin
      phase    <= '0;
      osc_edge <= 1'b0;
    end else begin
      phase    <= sum[15:0];
      osc_edge <= sum[16];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void expect_cal(input int tgt, output int ev, output int eb,
                                     output int ef, output int n);
    bit found = 1'b0;
    ev = 2; eb = 127; ef = 1; n = 384;
    for (int v = 0; v < 3; v++) begin
      for (int b = 0; b < 128; b++) begin
        if (!found && (((base_rate(v) - b * STEP) * (WIN - 1)) >>> 16) <= tgt) begin
          found = 1'b1;
          ev = v; eb = b; ef = (b == 0 || b == 127) ? 1 : 0;
          n = v * 128 + b + 1;
        end
      end
    end
  endfunction

  task automatic do_cal(input int kind, input int da, input int db, input int bs,
                        input bit flip, input string tag);
    int ev, eb, ef, n, tgt, lat;
    tgt = (((bs != 0) ? db : da) * WIN) >>> 8;
    expect_cal(tgt, ev, eb, ef, n);
    lat = n * (WIN + 1) + 1;
    @(negedge clk);
    div_a = 10'(da); div_b = 10'(db); bank_sel = (bs != 0);
    if (kind == 0) begin
      enable = 1'b0;
      @(negedge clk);
      chk(!lock_en && !meas_gate, "R10", {tag, " low enable clears lock/gate"},
          int'(lock_en) + int'(meas_gate), 0);
      enable = 1'b1;
    end else begin
      relock = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    relock = 1'b0;
    if (flip) begin
      bank_sel = ~bank_sel; div_a = 10'd4; div_b = 10'd4;
    end
    chk(!meas_gate && cal_band == 0 && cal_osc == 0 && !cal_done, "R2",
        {tag, " arm cycle gate low at osc0/band0"}, int'(meas_gate) + int'(cal_band), 0);
    @(posedge clk);
    @(negedge clk);
    chk(meas_gate, "R4", {tag, " gate opens after arm"}, int'(meas_gate), 1);
    repeat (lat - 2) @(posedge clk);
    @(negedge clk);
    chk(!cal_done, "R9", {tag, " done not early"}, int'(cal_done), 0);
    @(posedge clk);
    @(negedge clk);
    chk(cal_done && lock_en, "R9", {tag, " done and lock_en on time"},
        int'(cal_done) + int'(lock_en), 2);
    chk(int'(cal_osc) == ev, "R7", {tag, " oscillator"}, int'(cal_osc), ev);
    chk(int'(cal_band) == eb, "R6", {tag, " band"}, int'(cal_band), eb);
    chk(int'(cal_fail) == ef, "R8", {tag, " fail flag"}, int'(cal_fail), ef);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!meas_gate && cal_osc == 0 && cal_band == 0 && !cal_done && !cal_fail && !lock_en,
        "R1", "reset outputs", int'(cal_band) + int'(cal_done) + int'(lock_en), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++)
      do_cal(TV[i][0], TV[i][1], TV[i][2], TV[i][3], 1'b0, $sformatf("vec%0d", i));

    // R11: result holds while enabled and idle
    begin
      int hb, ho, hf;
      hb = int'(cal_band); ho = int'(cal_osc); hf = int'(cal_fail);
      repeat (20) @(negedge clk);
      chk(int'(cal_band) == hb && int'(cal_osc) == ho && cal_done, "R11", "hold band while enabled",
          int'(cal_band), hb);
      // R3: relock with enable low is ignored; R11: readback held with enable low
      enable = 1'b0;
      @(negedge clk);
      relock = 1'b1;
      @(negedge clk);
      relock = 1'b0;
      repeat (3) @(negedge clk);
      chk(!meas_gate && cal_done && !lock_en, "R3", "relock ignored while disabled",
          int'(meas_gate) + int'(lock_en), 0);
      chk(int'(cal_band) == hb && int'(cal_fail) == hf, "R11", "hold band while disabled",
          int'(cal_band), hb);
    end

    // R5: bank and divider changes after the trigger are ignored
    do_cal(0, 200, 80, 0, 1'b1, "latch_a");
    do_cal(0, 13, 80, 1, 1'b1, "latch_b");

    // R3: relock in the middle of a long search restarts it
    @(negedge clk);
    div_a = 10'd20; bank_sel = 1'b0; enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    repeat (150) @(negedge clk);
    chk(meas_gate || cal_band != 0, "R3", "search running before relock", int'(cal_band), 1);
    do_cal(1, 200, 0, 0, 1'b0, "restart");

    // R10: dropping enable mid-search stops it
    @(negedge clk);
    div_a = 10'd20; enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    repeat (100) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!meas_gate && !lock_en && !cal_done, "R10", "abort on enable low",
        int'(meas_gate) + int'(lock_en) + int'(cal_done), 0);
    repeat (WIN * 2) @(negedge clk);
    chk(!meas_gate && !cal_done, "R10", "stays stopped", int'(meas_gate) + int'(cal_done), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule